// File: doc/BRIEF.md
# Status-Controlled Banked Register File

This block holds the architectural register state for a processor core: sixteen integer registers and sixteen floating-point registers. The lower eight integer registers exist twice. The floating-point file exists twice in full. A status word chooses which integer copy is visible, and a floating-point control word chooses which floating-point copy is visible. An execution pipeline reads registers through combinational ports, writes them through synchronous ports, and changes banks only by writing the two control words.

A bank change toggles a selector. No data moves. The change is visible from the cycle after the control write. The condition flags T, S, Q and M are kept as separate bits. They are written from a status write, T can also be updated on its own, and all four are merged back into the status word when it is read. A three-bit mode code summarises the privilege bit and the floating-point size and precision bits for decode logic further on.

Top module: `bankreg_file`

## Requirements
- R1: After reset, the status read gives 0x700000F0, the FP control read gives 0x00080001, the mode code is 3'b101, and every integer and floating-point register reads zero.
- R2: The alternate integer bank is active only when status bit 30 (privilege) and status bit 29 (bank) are both 1. R0–R7 then map to the alternate copy. R8–R15 are the same physical registers in either bank.
- R3: A bank change takes effect from the clock edge that stores the control write. A read in that same cycle returns the old bank. A register write in that same cycle lands in the old bank.
- R4: A status write stores only the bits in the writable mask 0x700083F3. All other bits read back as zero.
- R5: The T flag (bit 0), the S flag (bit 1), the Q flag (bit 8) and the M flag (bit 9) are captured from every status write. A separate T update (tflag_we) changes only T. When both happen in the same cycle, the status write wins.
- R6: The status read is the stored word with bits 0, 1, 8 and 9 cleared and then replaced by the current flag bits.
- R7: FP control bit 21 selects the active copy of all sixteen floating-point registers. A write that changes bit 21 swaps the copies from the next cycle. A write that leaves bit 21 unchanged keeps the current copy.
- R8: An FP control write stores only the bits in the mask 0x003FFFFF, and fp_rdata returns the stored value.
- R9: The mode code is {status bit 30, FP control bit 20, FP control bit 19}. It changes on the edge that stores either control write, using the new values of both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpr_raddr | input | 4 | Integer register read address |
| gpr_rdata | output | 32 | Integer register read data (combinational) |
| gpr_we | input | 1 | Integer register write enable |
| gpr_waddr | input | 4 | Integer register write address |
| gpr_wdata | input | 32 | Integer register write data |
| fpr_raddr | input | 4 | Floating-point register read address |
| fpr_rdata | output | 32 | Floating-point register read data (combinational) |
| fpr_we | input | 1 | Floating-point register write enable |
| fpr_waddr | input | 4 | Floating-point register write address |
| fpr_wdata | input | 32 | Floating-point register write data |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 32 | Status word write value |
| sr_rdata | output | 32 | Status word with the flags merged in |
| tflag_we | input | 1 | Update the T flag alone |
| tflag_in | input | 1 | New T flag value |
| fp_we | input | 1 | FP control word write enable |
| fp_wdata | input | 32 | FP control word write value |
| fp_rdata | output | 32 | Stored FP control word |
| mode_code | output | 3 | {privilege, FP size, FP precision} |

## Verification
A wrong bank selector shows up on the read ports in the first cycle after the control write. R0–R7, or any FP register, then return data written under the other bank, while R8–R15 stay unchanged. The bench writes distinct values into each copy so that this mismatch is visible. A flag held in the wrong place shows up at once on sr_rdata, because the merge is combinational. A stale mode code is visible one edge after the write that should have changed it.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int CW = 32;

  // status word fields
  localparam int SR_T    = 0;
  localparam int SR_S    = 1;
  localparam int SR_Q    = 8;
  localparam int SR_M    = 9;
  localparam int SR_BANK = 29;
  localparam int SR_PRIV = 30;
  localparam logic [CW-1:0] SR_WMASK = 32'h7000_83F3;
  localparam logic [CW-1:0] SR_FLAGS = 32'h0000_0303;
  localparam logic [CW-1:0] SR_RESET = 32'h7000_00F0;

  // FP control fields
  localparam int FP_PR = 19;
  localparam int FP_SZ = 20;
  localparam int FP_FR = 21;
  localparam logic [CW-1:0] FP_WMASK = 32'h003F_FFFF;
  localparam logic [CW-1:0] FP_RESET = 32'h0008_0001;

  typedef struct packed {
    logic m;
    logic q;
    logic s;
    logic t;
  } flags_t;

  function automatic logic int_alt(input logic [CW-1:0] sr);
    return sr[SR_PRIV] & sr[SR_BANK];
  endfunction

  function automatic flags_t flags_of(input logic [CW-1:0] w);
    flags_t f;
    f.t = w[SR_T];
    f.s = w[SR_S];
    f.q = w[SR_Q];
    f.m = w[SR_M];
    return f;
  endfunction

  function automatic logic [CW-1:0] sr_merge(input logic [CW-1:0] stored,
                                             input flags_t f);
    logic [CW-1:0] w;
    w = stored & ~SR_FLAGS;
    w[SR_T] = f.t;
    w[SR_S] = f.s;
    w[SR_Q] = f.q;
    w[SR_M] = f.m;
    return w;
  endfunction

  function automatic logic [2:0] mode_of(input logic [CW-1:0] sr,
                                         input logic [CW-1:0] fp);
    return {sr[SR_PRIV], fp[FP_SZ], fp[FP_PR]};
  endfunction

endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_we,
  input  logic [CW-1:0] sr_wdata,
  input  logic          tflag_we,
  input  logic          tflag_in,
  input  logic          fp_we,
  input  logic [CW-1:0] fp_wdata,
  output logic [CW-1:0] sr_rdata,
  output logic [CW-1:0] fp_rdata,
  output logic          int_sel,
  output logic          fp_sel,
  output logic [2:0]    mode_code
);

  logic [CW-1:0] sr_q, fp_q, sr_n, fp_n;
  flags_t        flg_q;
  logic [2:0]    mode_q;

  // named events for the checks
  logic int_swap_ev, fp_swap_ev;

  assign sr_n = sr_we ? (sr_wdata & SR_WMASK) : sr_q;
  assign fp_n = fp_we ? (fp_wdata & FP_WMASK) : fp_q;

  assign int_swap_ev = sr_we && (int_alt(sr_n) != int_alt(sr_q));
  assign fp_swap_ev  = fp_we && (fp_n[FP_FR] != fp_q[FP_FR]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= SR_RESET & SR_WMASK;
      flg_q  <= flags_of(SR_RESET);
      fp_q   <= FP_RESET & FP_WMASK;
      mode_q <= mode_of(SR_RESET, FP_RESET);
    end else begin
      sr_q <= sr_n;
      fp_q <= fp_n;
      if (sr_we)
        flg_q <= flags_of(sr_wdata);
      else if (tflag_we)
        flg_q.t <= tflag_in;
      if (sr_we || fp_we)
        mode_q <= mode_of(sr_n, fp_n);
    end
  end

  assign sr_rdata  = sr_merge(sr_q, flg_q);
  assign fp_rdata  = fp_q;
  assign int_sel   = int_alt(sr_q);
  assign fp_sel    = fp_q[FP_FR];
  assign mode_code = mode_q;

  // R2 / R3: integer bank pointer flips exactly on a combined-condition change
  a_r2_int_swap: assert property (@(posedge clk) disable iff (!rst_n)
    int_swap_ev |=> (int_sel != $past(int_sel)));
  a_r2_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !int_swap_ev |=> $stable(int_sel));
  // R7: FP bank pointer follows FR toggles only
  a_r7_fp_swap: assert property (@(posedge clk) disable iff (!rst_n)
    fp_swap_ev |=> (fp_sel != $past(fp_sel)));
  a_r7_fp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_swap_ev |=> $stable(fp_sel));
  // R4: non-writable status bits never appear
  a_r4_sr_mask: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> ((sr_rdata & ~SR_WMASK) == '0));
  // R5: status write captures T and wins over a T update
  a_r5_t_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> (sr_rdata[SR_T] == $past(sr_wdata[SR_T])));
  // R9: mode code matches the words after any control write
  a_r9_mode_track: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we || fp_we) |=> (mode_code == {sr_rdata[SR_PRIV], fp_rdata[FP_SZ], fp_rdata[FP_PR]}));

endmodule

// File: rtl/bankreg_gpr.sv
module bankreg_gpr #(
  parameter int W       = 32,
  parameter int NREG    = 16,
  parameter int NBANKED = 8,
  localparam int AW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);

  logic [NREG-1:0][W-1:0] view;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i < NBANKED) begin : g_banked
      logic [W-1:0] copy0, copy1;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          copy0 <= '0;
          copy1 <= '0;
        end else if (we && (waddr == AW'(i))) begin
          if (sel) copy1 <= wdata;
          else     copy0 <= wdata;
        end
      end
      assign view[i] = sel ? copy1 : copy0;
    end else begin : g_shared
      logic [W-1:0] word;
      always_ff @(posedge clk) begin
        if (!rst_n)
          word <= '0;
        else if (we && (waddr == AW'(i)))
          word <= wdata;
      end
      assign view[i] = word;
    end
  end

  assign rdata = view[raddr];

  // R3: a write lands in the bank that was active in its own cycle
  a_r3_gpr_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !($past(we) && 1'b0)) |=>
      ((view[$past(waddr)] == $past(wdata)) || (sel != $past(sel))));

endmodule

// File: rtl/bankreg_fpr.sv
module bankreg_fpr #(
  parameter int W    = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);

  logic [NREG-1:0][W-1:0] view;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [W-1:0] copy0, copy1;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        copy0 <= '0;
        copy1 <= '0;
      end else if (we && (waddr == AW'(i))) begin
        if (sel) copy1 <= wdata;
        else     copy0 <= wdata;
      end
    end
    assign view[i] = sel ? copy1 : copy0;
  end

  assign rdata = view[raddr];

  // R7: a write lands in the FP bank active in its own cycle
  a_r7_fpr_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((view[$past(waddr)] == $past(wdata)) || (sel != $past(sel))));

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_GPR    = 16,
  parameter int NUM_BANKED = 8,
  parameter int NUM_FPR    = 16,
  localparam int GAW       = $clog2(NUM_GPR),
  localparam int FAW       = $clog2(NUM_FPR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAW-1:0]    gpr_raddr,
  output logic [DATA_W-1:0] gpr_rdata,
  input  logic              gpr_we,
  input  logic [GAW-1:0]    gpr_waddr,
  input  logic [DATA_W-1:0] gpr_wdata,
  input  logic [FAW-1:0]    fpr_raddr,
  output logic [DATA_W-1:0] fpr_rdata,
  input  logic              fpr_we,
  input  logic [FAW-1:0]    fpr_waddr,
  input  logic [DATA_W-1:0] fpr_wdata,
  input  logic              sr_we,
  input  logic [CW-1:0]     sr_wdata,
  output logic [CW-1:0]     sr_rdata,
  input  logic              tflag_we,
  input  logic              tflag_in,
  input  logic              fp_we,
  input  logic [CW-1:0]     fp_wdata,
  output logic [CW-1:0]     fp_rdata,
  output logic [2:0]        mode_code
);

  logic int_sel, fp_sel;

  bankreg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_we     (sr_we),
    .sr_wdata  (sr_wdata),
    .tflag_we  (tflag_we),
    .tflag_in  (tflag_in),
    .fp_we     (fp_we),
    .fp_wdata  (fp_wdata),
    .sr_rdata  (sr_rdata),
    .fp_rdata  (fp_rdata),
    .int_sel   (int_sel),
    .fp_sel    (fp_sel),
    .mode_code (mode_code)
  );

  bankreg_gpr #(.W(DATA_W), .NREG(NUM_GPR), .NBANKED(NUM_BANKED)) u_gpr (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (int_sel),
    .raddr (gpr_raddr),
    .rdata (gpr_rdata),
    .we    (gpr_we),
    .waddr (gpr_waddr),
    .wdata (gpr_wdata)
  );

  bankreg_fpr #(.W(DATA_W), .NREG(NUM_FPR)) u_fpr (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (fp_sel),
    .raddr (fpr_raddr),
    .rdata (fpr_rdata),
    .we    (fpr_we),
    .waddr (fpr_waddr),
    .wdata (fpr_wdata)
  );

endmodule

// File: tb/bankreg_file_bench.sv
module bankreg_file_bench;

  localparam int P_GPR = 0, P_FPR = 1, P_SR = 2, P_FP = 3, P_MODE = 4;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  gpr_raddr = 0, gpr_waddr = 0, fpr_raddr = 0, fpr_waddr = 0;
  logic [31:0] gpr_rdata, gpr_wdata = 0, fpr_rdata, fpr_wdata = 0;
  logic        gpr_we = 0, fpr_we = 0, sr_we = 0, tflag_we = 0, tflag_in = 0, fp_we = 0;
  logic [31:0] sr_wdata = 0, sr_rdata, fp_wdata = 0, fp_rdata;
  logic [2:0]  mode_code;

  int total = 0, fails = 0;
  bit done = 0;

  typedef struct {
    int          port;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  event chk_ev;

  always #10 clk = ~clk;

  bankreg_file u_bankreg_file (
    .clk(clk), .rst_n(rst_n),
    .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata), .gpr_we(gpr_we),
    .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .fpr_raddr(fpr_raddr), .fpr_rdata(fpr_rdata), .fpr_we(fpr_we),
    .fpr_waddr(fpr_waddr), .fpr_wdata(fpr_wdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .tflag_we(tflag_we), .tflag_in(tflag_in),
    .fp_we(fp_we), .fp_wdata(fp_wdata), .fp_rdata(fp_rdata),
    .mode_code(mode_code)
  );

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.port)
          P_GPR:   act = gpr_rdata;
          P_FPR:   act = fpr_rdata;
          P_SR:    act = sr_rdata;
          P_FP:    act = fp_rdata;
          default: act = {29'd0, mode_code};
        endcase
        total++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk(input int port, input logic [31:0] exp, input string tag);
    item_t it;
    it.port = port; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic rd_gpr(input int a, input logic [31:0] exp, input string tag);
    gpr_raddr = 4'(a); #1; chk(P_GPR, exp, tag);
  endtask

  task automatic rd_fpr(input int a, input logic [31:0] exp, input string tag);
    fpr_raddr = 4'(a); #1; chk(P_FPR, exp, tag);
  endtask

  task automatic wr_gpr(input int a, input logic [31:0] v);
    @(negedge clk); gpr_we = 1; gpr_waddr = 4'(a); gpr_wdata = v;
    @(negedge clk); gpr_we = 0; #1;
  endtask

  task automatic wr_fpr(input int a, input logic [31:0] v);
    @(negedge clk); fpr_we = 1; fpr_waddr = 4'(a); fpr_wdata = v;
    @(negedge clk); fpr_we = 0; #1;
  endtask

  task automatic wr_sr(input logic [31:0] v);
    @(negedge clk); sr_we = 1; sr_wdata = v;
    @(negedge clk); sr_we = 0; #1;
  endtask

  task automatic wr_fp(input logic [31:0] v);
    @(negedge clk); fp_we = 1; fp_wdata = v;
    @(negedge clk); fp_we = 0; #1;
  endtask

  task automatic wr_t(input logic v);
    @(negedge clk); tflag_we = 1; tflag_in = v;
    @(negedge clk); tflag_we = 0; #1;
  endtask

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(P_SR, 32'h7000_00F0, "R1 status reset");
    chk(P_FP, 32'h0008_0001, "R1 fp control reset");
    chk(P_MODE, 32'd5, "R1 mode reset");
    rd_gpr(0, 0, "R1 R0 reset");
    rd_gpr(15, 0, "R1 R15 reset");
    rd_fpr(0, 0, "R1 F0 reset");

    // R2 integer banks (alternate active after reset)
    wr_gpr(0, 32'hA1);
    wr_gpr(8, 32'hB8);
    wr_sr(32'h0000_00F0);
    rd_gpr(0, 0, "R2 R0 normal bank empty");
    rd_gpr(8, 32'hB8, "R2 R8 shared");
    wr_gpr(0, 32'hA0);
    wr_sr(32'h7000_00F0);
    rd_gpr(0, 32'hA1, "R2 R0 alternate bank");
    wr_sr(32'h2000_00F0);
    rd_gpr(0, 32'hA0, "R2 bank bit alone");
    wr_sr(32'h4000_00F0);
    rd_gpr(0, 32'hA0, "R2 priv bit alone");

    // R3 same-cycle behaviour
    @(negedge clk);
    sr_we = 1; sr_wdata = 32'h7000_00F0;
    gpr_we = 1; gpr_waddr = 4'd1; gpr_wdata = 32'hC1;
    gpr_raddr = 4'd0;
    #1;
    chk(P_GPR, 32'hA0, "R3 read in swap cycle sees old bank");
    @(negedge clk); sr_we = 0; gpr_we = 0; #1;
    rd_gpr(0, 32'hA1, "R3 new bank next cycle");
    rd_gpr(1, 0, "R3 write not in new bank");
    wr_sr(32'h0000_0000);
    rd_gpr(1, 32'hC1, "R3 write landed in old bank");

    // R4 mask
    wr_sr(32'hFFFF_FFFF);
    chk(P_SR, 32'h7000_83F3, "R4 status mask");
    rd_gpr(0, 32'hA1, "R2 all-ones selects alternate");

    // R5 / R6 flags
    wr_sr(32'h0000_0000);
    chk(P_SR, 32'h0, "R5 cleared");
    wr_t(1'b1);
    chk(P_SR, 32'h1, "R5 T update alone");
    @(negedge clk);
    sr_we = 1; sr_wdata = 32'h0000_0302; tflag_we = 1; tflag_in = 1;
    @(negedge clk); sr_we = 0; tflag_we = 0; #1;
    chk(P_SR, 32'h0000_0302, "R5 status write wins over T update");
    wr_t(1'b1);
    chk(P_SR, 32'h0000_0303, "R6 merge T into word");
    wr_sr(32'h0000_0301);
    wr_t(1'b0);
    chk(P_SR, 32'h0000_0300, "R6 stored T position cleared");

    // R7 FP banks, R9 mode
    wr_fpr(3, 32'hF0F0);
    wr_fpr(15, 32'h1515);
    wr_fp(32'h0030_0000);
    rd_fpr(3, 0, "R7 F3 other bank");
    rd_fpr(15, 0, "R7 F15 other bank");
    chk(P_MODE, 32'd2, "R9 mode after fp write");
    wr_fpr(3, 32'hBEEF);
    wr_fp(32'h0010_0000);
    rd_fpr(3, 32'hF0F0, "R7 F3 swapped back");
    rd_fpr(15, 32'h1515, "R7 F15 swapped back");
    wr_fp(32'h0000_0000);
    rd_fpr(3, 32'hF0F0, "R7 no FR change keeps bank");

    // R8 mask
    wr_fp(32'hFFFF_FFFF);
    chk(P_FP, 32'h003F_FFFF, "R8 fp control mask");
    rd_fpr(3, 32'hBEEF, "R7 FR set from all-ones");
    chk(P_MODE, 32'd3, "R9 mode sz pr");

    // R9 timing
    @(negedge clk); sr_we = 1; sr_wdata = 32'h4000_0000; #1;
    chk(P_MODE, 32'd3, "R9 mode unchanged before edge");
    @(negedge clk); sr_we = 0; #1;
    chk(P_MODE, 32'd7, "R9 mode after status write");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule